// File: doc/BRIEF.md
# Byte-Serial Register Port Slave

This block is the target side of a chip-select framed serial link that moves one bit per strobe, with mode-0 timing and the most significant bit first. Each frame opens with a header. The first header bit selects the header format. A 16-bit header addresses a small command space. A 32-bit header addresses a wider register space. The header also says whether the access reads or writes.

Data bytes follow the header. Each byte goes to the next address in the chosen space until chip select is released. Read bytes appear on the serial output as soon as the header is complete. An all-zero short read header is a probe: it returns a fixed 32-bit identification word in place of register data.

Both spaces are plain byte memories. Wider values are stored with the low byte at the lower address. A set of register-space bytes, chosen by a parameter mask, hold the upper half of 12-bit values. Those bytes keep only their low nibble.

Top module: `serial_regport`

## Requirements
- R1: After reset `sdo` is 0 and every byte in both spaces reads as 0x00.
- R2: The first header bit selects the header length: 0 gives a 16-bit header for the command space, and 1 gives a 32-bit header for the register space. The two spaces are separate storage.
- R3: In a short header, bit 14 set means write and bits 13:8 give the command address. The command space has 64 bytes, and address increment wraps from 0x3F to 0x00.
- R4: In a long header, bit 31 is 1, bit 30 set means write, and bits 23:8 give a 16-bit address. That address is reduced modulo the register depth (default 256).
- R5: A short header equal to 0x0000, read, returns the bytes 0x04, 0x02, 0x02, 0x00 (the word 0x04020200, most significant byte first). Any further bytes in that frame return 0x00.
- R6: The data bytes of a frame go to, or come from, consecutive addresses starting at the header address, until chip select goes high.
- R7: In a read, the first data bit is on `sdo` right after the strobe that carries the last header bit. Each byte is sent MSB first, and each strobe advances `sdo` by one bit.
- R8: A value written as consecutive bytes reads back low byte first. A byte at a masked register address keeps only bits 3:0 and reads 0 in bits 7:4. The default mask covers addresses 0x0B, 0x0D, 0x0F, 0x13, 0x17, 0x19 and 0x1B.
- R9: Raising chip select before the header is complete, or before the 8th bit of a write byte, leaves every byte unchanged.
- R10: `sdo` is 0 while chip select is high, during the header and during write data.
- R11: Cycles with `bit_en` low change nothing: a transfer with idle cycles between bits gives the same result as one without.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| bit_en | input | 1 | Strobe: one serial bit is transferred in each cycle where this is high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |

## Verification
A wrong header bit count or format choice shows up at once: the first read byte comes out shifted or from the wrong space. A stale address or a missed increment appears in the second byte of any multi-byte transfer. A write strobe in the wrong place is silent until a later read frame returns the corrupted byte. For that reason every write scenario reads its bytes back in a separate frame. The abort case reads back a byte that was set beforehand.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} srp_phase_e;

  typedef struct packed {
    logic        wr;
    logic        id_hit;
    logic [15:0] addr;
  } srp_hdr_t;
endpackage

// File: rtl/srp_hdr_dec.sv
module srp_hdr_dec
  import srp_pkg::*;
(
  input  logic        long_fmt,
  input  logic [31:0] word,
  output srp_hdr_t    hdr
);
  logic unused_hdr_bits;
  assign unused_hdr_bits = ^{word[31], word[29:24]};

  always_comb begin
    if (long_fmt) begin
      hdr.wr     = word[30];
      hdr.addr   = word[23:8];
      hdr.id_hit = 1'b0;
    end else begin
      hdr.wr     = word[14];
      hdr.addr   = {10'd0, word[13:8]};
      hdr.id_hit = (word[15:0] == 16'h0000);
    end
  end
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int              DEPTH = 64,
  parameter logic [DEPTH-1:0] MASK = '0,
  localparam int             AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0] cell_q;
    logic [7:0] cell_d;
    logic       cell_en;

    assign cell_en = we && (waddr == AW'(i));

    if (MASK[i]) begin : g_nib
      assign cell_d = {4'h0, wdata[3:0]};
    end else begin : g_full
      assign cell_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'h00;
      else if (cell_en) cell_q <= cell_d;
    end

    assign cells[i] = cell_q;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import srp_pkg::*;
#(
  parameter int                  CMD_DEPTH = 64,
  parameter int                  REG_DEPTH = 256,
  parameter logic [REG_DEPTH-1:0] NIB_MASK = REG_DEPTH'(32'h0A88_A800),
  parameter logic [31:0]         ID_WORD   = 32'h0402_0200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic bit_en,
  input  logic sdi,
  output logic sdo
);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int RAW = $clog2(REG_DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  srp_phase_e  phase_q, phase_d;
  logic [4:0]  hcnt_q, hcnt_d;
  logic [30:0] hsr_q, hsr_d;
  logic        long_q, long_d, wr_q, wr_d, id_q, id_d;
  logic [15:0] addr_q, addr_d;
  logic [7:0]  dsr_q, dsr_d;
  logic [2:0]  dcnt_q, dcnt_d, idx_q, idx_d;

  logic        step, first_long, hdr_last, byte_last;
  logic [31:0] hword;
  srp_hdr_t    dec;
  logic [15:0] addr_nxt;
  logic        long_sel, id_sel;
  logic [2:0]  idx_nxt;
  logic [7:0]  id_byte, rd_byte, wbyte, cmd_rdata, reg_rdata;
  logic        we_cmd, we_reg;

  assign step       = !cs_n && bit_en;
  assign first_long = (hcnt_q == 5'd0) ? sdi : long_q;
  assign hword      = {hsr_q, sdi};
  assign hdr_last   = (phase_q == PH_HDR) && step &&
                      (hcnt_q == (first_long ? 5'd31 : 5'd15));
  assign byte_last  = (phase_q == PH_DATA) && step && (dcnt_q == 3'd7);

  srp_hdr_dec u_dec (.long_fmt(first_long), .word(hword), .hdr(dec));

  assign addr_nxt = hdr_last ? dec.addr : addr_q + 16'd1;
  assign long_sel = hdr_last ? first_long : long_q;
  assign id_sel   = hdr_last ? (dec.id_hit && !dec.wr) : id_q;
  assign idx_nxt  = hdr_last ? 3'd0 : ((idx_q == 3'd4) ? 3'd4 : idx_q + 3'd1);

  always_comb begin
    case (idx_nxt)
      3'd0:    id_byte = ID_WORD[31:24];
      3'd1:    id_byte = ID_WORD[23:16];
      3'd2:    id_byte = ID_WORD[15:8];
      3'd3:    id_byte = ID_WORD[7:0];
      default: id_byte = 8'h00;
    endcase
  end

  assign rd_byte = id_sel ? id_byte : (long_sel ? reg_rdata : cmd_rdata);
  assign wbyte   = {dsr_q[6:0], sdi};
  assign we_cmd  = byte_last && wr_q && !long_q;
  assign we_reg  = byte_last && wr_q && long_q;

  srp_regfile #(.DEPTH(CMD_DEPTH), .MASK('0)) u_cmd_space (
    .clk(clk), .rst_n(rst_i), .we(we_cmd), .waddr(addr_q[CAW-1:0]),
    .wdata(wbyte), .raddr(addr_nxt[CAW-1:0]), .rdata(cmd_rdata));

  srp_regfile #(.DEPTH(REG_DEPTH), .MASK(NIB_MASK)) u_reg_space (
    .clk(clk), .rst_n(rst_i), .we(we_reg), .waddr(addr_q[RAW-1:0]),
    .wdata(wbyte), .raddr(addr_nxt[RAW-1:0]), .rdata(reg_rdata));

  always_comb begin
    phase_d = phase_q; hcnt_d = hcnt_q; hsr_d = hsr_q;
    long_d  = long_q;  wr_d   = wr_q;   id_d  = id_q;
    addr_d  = addr_q;  dsr_d  = dsr_q;  dcnt_d = dcnt_q; idx_d = idx_q;
    if (cs_n) begin
      phase_d = PH_HDR;
      hcnt_d  = 5'd0;
      dcnt_d  = 3'd0;
    end else if (bit_en) begin
      if (phase_q == PH_HDR) begin
        hsr_d  = {hsr_q[29:0], sdi};
        hcnt_d = hcnt_q + 5'd1;
        long_d = first_long;
        if (hdr_last) begin
          phase_d = PH_DATA;
          wr_d    = dec.wr;
          id_d    = id_sel;
          addr_d  = addr_nxt;
          idx_d   = idx_nxt;
          dcnt_d  = 3'd0;
          dsr_d   = dec.wr ? 8'h00 : rd_byte;
        end
      end else begin
        dcnt_d = dcnt_q + 3'd1;
        dsr_d  = wr_q ? wbyte : {dsr_q[6:0], 1'b0};
        if (byte_last) begin
          addr_d = addr_nxt;
          idx_d  = idx_nxt;
          if (!wr_q) dsr_d = rd_byte;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q <= PH_HDR; hcnt_q <= '0; hsr_q <= '0;
      long_q  <= 1'b0;   wr_q   <= 1'b0; id_q <= 1'b0;
      addr_q  <= '0;     dsr_q  <= '0;   dcnt_q <= '0; idx_q <= '0;
    end else begin
      phase_q <= phase_d; hcnt_q <= hcnt_d; hsr_q <= hsr_d;
      long_q  <= long_d;  wr_q   <= wr_d;   id_q  <= id_d;
      addr_q  <= addr_d;  dsr_q  <= dsr_d;  dcnt_q <= dcnt_d; idx_q <= idx_d;
    end
  end

  assign sdo = (!cs_n && (phase_q == PH_DATA) && !wr_q) ? dsr_q[7] : 1'b0;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       bit_en,
  input srp_phase_e phase_q,
  input logic       we_cmd,
  input logic       we_reg
);
  // R9: no byte is stored while a header is still being collected
  assert_no_hdr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HDR) |-> !(we_cmd || we_reg));

  // R2: one access touches one space only
  assert_one_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_cmd, we_reg}));

  // R11: a store needs a strobe inside an open frame
  assert_write_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we_cmd || we_reg) |-> (bit_en && !cs_n));

  // R6: releasing the frame returns to header collection
  assert_frame_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_HDR));

  // R11: idle cycles inside a frame leave the phase alone
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !bit_en) |=> $stable(phase_q));
endmodule

bind serial_regport srp_checker u_chk (
  .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .bit_en(bit_en),
  .phase_q(phase_q), .we_cmd(we_cmd), .we_reg(we_reg));

// File: tb/serial_regport_bench.sv
module serial_regport_bench;
  logic clk, rst_n, cs_n, bit_en, sdi, sdo;
  int   errs, checks, gap;
  logic sdo_seen;
  logic [7:0] rb;

  serial_regport u_serial_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi), .sdo(sdo));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    r = sdo;
    sdo_seen = sdo_seen | sdo;
    sdi = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic byte_x(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) bit_x(d[i], q[i]);
  endtask

  task automatic hdr_bits(input logic [31:0] h, input int n);
    logic r;
    for (int i = n - 1; i >= 0; i--) bit_x(h[i], r);
  endtask

  task automatic open_f;
    @(negedge clk); cs_n = 1'b0; sdo_seen = 1'b0;
  endtask

  task automatic close_f;
    cs_n = 1'b1; @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    checks++;
    if (sdo !== 1'b0) begin errs++; $display("FAIL R1: sdo got %b expected 0", sdo); end
    open_f; hdr_bits(32'h0000_0500, 16); byte_x(8'h00, rb); close_f;
    check8("R1 cmd 0x05", rb, 8'h00);
    open_f; hdr_bits(32'h8000_4000, 32); byte_x(8'h00, rb); close_f;
    check8("R1 reg 0x40", rb, 8'h00);
  endtask

  task automatic t_id;
    logic [7:0] exp [5] = '{8'h04, 8'h02, 8'h02, 8'h00, 8'h00};
    open_f; hdr_bits(32'h0, 16);
    for (int k = 0; k < 5; k++) begin byte_x(8'h00, rb); check8("R5 R7 id byte", rb, exp[k]); end
    close_f;
  endtask

  task automatic t_cmd;
    open_f; hdr_bits(32'h0000_4500, 16); byte_x(8'hA5, rb); byte_x(8'h3C, rb); close_f;
    checks++;
    if (sdo_seen !== 1'b0) begin errs++; $display("FAIL R10: sdo got 1 expected 0 during write"); end
    open_f; hdr_bits(32'h0000_0500, 16); byte_x(8'h00, rb); check8("R3 cmd 0x05", rb, 8'hA5);
    byte_x(8'h00, rb); check8("R6 cmd 0x06", rb, 8'h3C); close_f;
    open_f; hdr_bits(32'h0000_7F00, 16); byte_x(8'h11, rb); byte_x(8'h22, rb); close_f;
    open_f; hdr_bits(32'h0000_3F00, 16); byte_x(8'h00, rb); check8("R3 cmd 0x3F", rb, 8'h11);
    byte_x(8'h00, rb); check8("R3 wrap to 0x00", rb, 8'h22); close_f;
  endtask

  task automatic t_reg;
    open_f; hdr_bits(32'hC012_3400, 32);
    byte_x(8'h01, rb); byte_x(8'h02, rb); byte_x(8'h03, rb); close_f;
    open_f; hdr_bits(32'h8000_3400, 32); byte_x(8'h00, rb); check8("R4 alias 0x34", rb, 8'h01);
    byte_x(8'h00, rb); check8("R6 reg 0x35", rb, 8'h02);
    byte_x(8'h00, rb); check8("R6 reg 0x36", rb, 8'h03); close_f;
    open_f; hdr_bits(32'h8000_0500, 32); byte_x(8'h00, rb); close_f;
    check8("R2 separate spaces", rb, 8'h00);
  endtask

  task automatic t_nibble;
    open_f; hdr_bits(32'hC000_0A00, 32);
    byte_x(8'hBC, rb); byte_x(8'hAB, rb); byte_x(8'hFF, rb); byte_x(8'hFF, rb); close_f;
    open_f; hdr_bits(32'h8000_0A00, 32);
    byte_x(8'h00, rb); check8("R8 low byte 0x0A", rb, 8'hBC);
    byte_x(8'h00, rb); check8("R8 masked 0x0B", rb, 8'h0B);
    byte_x(8'h00, rb); check8("R8 unmasked 0x0C", rb, 8'hFF);
    byte_x(8'h00, rb); check8("R8 masked 0x0D", rb, 8'h0F); close_f;
  endtask

  task automatic t_abort;
    open_f; hdr_bits(32'h0000_5000, 16); byte_x(8'h77, rb); close_f;
    open_f; hdr_bits(32'h0000_0050, 8); close_f;
    open_f; hdr_bits(32'h0000_5000, 16); bit_x(1'b1, rb); bit_x(1'b0, rb); bit_x(1'b1, rb); close_f;
    open_f; hdr_bits(32'h0000_C000, 20); close_f;
    open_f; hdr_bits(32'h0000_1000, 16); byte_x(8'h00, rb); close_f;
    check8("R9 aborted writes", rb, 8'h77);
  endtask

  task automatic t_gap;
    gap = 2;
    open_f; hdr_bits(32'hC000_8000, 32); byte_x(8'h5A, rb); byte_x(8'hC3, rb); close_f;
    open_f; hdr_bits(32'h8000_8000, 32); byte_x(8'h00, rb); check8("R11 gapped 0x80", rb, 8'h5A);
    byte_x(8'h00, rb); check8("R11 gapped 0x81", rb, 8'hC3); close_f;
    gap = 0;
    checks++;
    if (sdo !== 1'b0) begin errs++; $display("FAIL R10: sdo idle got %b expected 0", sdo); end
  endtask

  initial begin
    errs = 0; checks = 0; gap = 0; sdo_seen = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; bit_en = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset; t_id; t_cmd; t_reg; t_nibble; t_abort; t_gap;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule